// File: doc/BRIEF.md
# CAN Nominal Bit Timing and Resynchronization Unit

This block divides each nominal CAN bit into time quanta and tracks where the node is inside the bit. The prescaler outside the block supplies one enable pulse per time quantum. Each bit has three parts in a fixed order: a one-quantum synchronization part, a first phase part, and a second phase part. The first phase part ends at the sample point, where the receive line is captured. The second phase part ends at the transmit point, where the next bit may be driven. The protocol engine uses the captured bit and the two strobes. Bit stuffing, framing and data-rate switching are handled outside this block.

The unit follows the bus edges so that it stays aligned with the other nodes. While the protocol engine reports an idle bus or an expected frame start, a dominant-going edge triggers a hard synchronization, which restarts the bit. At other times such an edge triggers a resynchronization. A late edge lengthens the first phase part. An early edge shortens the second phase part. In both cases the change is limited by a jump width, and that width is itself clamped to the length of the second phase part.

Top module: `can_bit_timing`

## Requirements
- R1: During reset and on release, `sample_o` and `tx_o` are 0 and `rx_bit_o` is 1.
- R2: With no adjustment, a bit lasts 1 + L1 + L2 quanta, where L1 = `seg1_cfg_i` + 1 and L2 = `seg2_cfg_i` + 1. `sample_o` follows the quantum that ends the first phase part. `tx_o` follows the quantum that ends the bit, and the next quantum is the synchronization quantum.
- R3: The line is captured only at the sample point. `sample_o` is high for exactly one clock, the clock after the enable edge. `rx_bit_o` then equals `rx_i` from that edge and holds until the next sample point.
- R4: An edge is a quantum whose `rx_i` is 0 when `rx_i` was 1 at the previous quantum. If `idle_i` is 1 at the edge quantum, a hard synchronization occurs. The next quantum is the first quantum of the first phase part, and no jump-width limit applies.
- R5: An edge in the synchronization quantum has zero phase error. It changes no segment length.
- R6: An edge in the k-th quantum of the first phase part (k ≥ 1) extends that part by min(k, SJW), where SJW = min(`sjw_cfg_i` + 1, L2).
- R7: An edge in 0-based quantum i of the second phase part has error e = L2 − i. If e ≤ SJW, the bit ends at that quantum (`tx_o` pulses) and the next quantum starts the first phase part. Otherwise the second phase part is shortened by SJW.
- R8: At most one synchronization event is applied per bit. Further edges in the same bit, and every rising edge, are ignored.
- R9: A jump width larger than L2 behaves as a jump width of exactly L2.
- R10: `sample_o` and `tx_o` never pulse in the same clock, and each pulses only in the clock after a quantum enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tq_en_i | input | 1 | One-clock pulse per time quantum |
| rx_i | input | 1 | Receive line, synchronous to clk_i, 1 = recessive |
| idle_i | input | 1 | High while a falling edge must hard-synchronize |
| seg1_cfg_i | input | SEG1_W | First phase part length minus one |
| seg2_cfg_i | input | SEG2_W | Second phase part length minus one |
| sjw_cfg_i | input | SJW_W | Jump width minus one |
| rx_bit_o | output | 1 | Value captured at the last sample point |
| sample_o | output | 1 | Sample point strobe |
| tx_o | output | 1 | Transmit point (bit end) strobe |

## Verification
The bench uses the default widths: four bits for the first phase part, three for the second and two for the jump width. This makes the full range of 1 to 16 quanta, 1 to 8 quanta and a jump width of 1 to 4 reachable. It also covers the shortest possible bit of three quanta, the longest bit including a four-quantum extension, and settings where the requested jump width exceeds the second phase part. With random edge placement across these settings, edges land in every quantum position. This exercises both the absorb-and-restart path and the shortening path of early edges.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    // Part of the nominal bit that the current quantum belongs to
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_ONE  = 2'd1,
        SEG_TWO  = 2'd2
    } seg_e;

endpackage

// File: rtl/can_bt_edge.sv
// Quantum-rate edge detector: flags a recessive-to-dominant transition
// between two consecutive quantum enables.
module can_bt_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tq_en_i,
    input  logic rx_i,
    output logic fall_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = prev_q;
        if (tq_en_i) begin
            prev_d = rx_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign fall_o = tq_en_i & prev_q & ~rx_i;

endmodule

// File: rtl/can_bt_phase.sv
// Phase error evaluation: clamps the jump width and derives the
// adjustment for a late edge (first part) and an early edge (second part).
module can_bt_phase #(
    parameter int LIM_W = 5
) (
    input  logic [LIM_W-1:0] idx_i,
    input  logic [LIM_W-1:0] seg2_len_i,
    input  logic [LIM_W-1:0] sjw_len_i,
    output logic [LIM_W-1:0] ext1_o,
    output logic [LIM_W-1:0] lim2_new_o,
    output logic             restart_o
);

    logic [LIM_W-1:0] sjw_eff;
    logic [LIM_W-1:0] late_err;
    logic [LIM_W-1:0] early_err;

    always_comb begin
        // jump width never exceeds the second phase part
        sjw_eff    = (sjw_len_i > seg2_len_i) ? seg2_len_i : sjw_len_i;
        // late edge: error counts quanta of the first part up to the edge
        late_err   = idx_i + LIM_W'(1);
        ext1_o     = (late_err > sjw_eff) ? sjw_eff : late_err;
        // early edge: error counts the quanta left until the next bit
        early_err  = seg2_len_i - idx_i;
        restart_o  = (early_err <= sjw_eff);
        lim2_new_o = seg2_len_i - sjw_eff;
    end

endmodule

// File: rtl/can_bt_seq.sv
// Quantum sequencer: walks sync / first part / second part, applies
// hard synchronization and single per-bit resynchronization.
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int LIM_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tq_en_i,
    input  logic             rx_i,
    input  logic             idle_i,
    input  logic             fall_i,
    input  logic [LIM_W-1:0] seg1_len_i,
    input  logic [LIM_W-1:0] seg2_len_i,
    input  logic [LIM_W-1:0] sjw_len_i,
    output logic             rx_bit_o,
    output logic             sample_o,
    output logic             tx_o
);

    typedef struct packed {
        seg_e             seg;
        logic [LIM_W-1:0] idx;
        logic [LIM_W-1:0] lim1;
        logic [LIM_W-1:0] lim2;
        logic             done;
        logic             bit_v;
        logic             smp;
        logic             txs;
    } st_t;

    st_t st_d, st_q;

    logic [LIM_W-1:0] ext1;
    logic [LIM_W-1:0] lim2_new;
    logic             restart;
    logic             resync;
    logic [LIM_W-1:0] lim1_now;
    logic [LIM_W-1:0] lim2_now;
    logic [LIM_W-1:0] idx_inc;

    can_bt_phase #(
        .LIM_W (LIM_W)
    ) u_phase (
        .idx_i      (st_q.idx),
        .seg2_len_i (seg2_len_i),
        .sjw_len_i  (sjw_len_i),
        .ext1_o     (ext1),
        .lim2_new_o (lim2_new),
        .restart_o  (restart)
    );

    always_comb begin
        st_d     = st_q;
        st_d.smp = 1'b0;
        st_d.txs = 1'b0;
        resync   = fall_i & ~st_q.done;
        lim1_now = resync ? (seg1_len_i + ext1) : st_q.lim1;
        lim2_now = resync ? lim2_new : st_q.lim2;
        idx_inc  = st_q.idx + LIM_W'(1);

        if (tq_en_i) begin
            if (fall_i && idle_i) begin
                // hard synchronization: next quantum opens the first part
                st_d.seg  = SEG_ONE;
                st_d.idx  = '0;
                st_d.lim1 = seg1_len_i;
                st_d.lim2 = seg2_len_i;
                st_d.done = 1'b1;
            end else begin
                case (st_q.seg)
                    SEG_SYNC: begin
                        st_d.seg  = SEG_ONE;
                        st_d.idx  = '0;
                        st_d.lim1 = seg1_len_i;
                        st_d.lim2 = seg2_len_i;
                        // edge inside sync: zero error, only consumes the event
                        st_d.done = fall_i;
                    end
                    SEG_ONE: begin
                        if (resync) begin
                            st_d.done = 1'b1;
                            st_d.lim1 = lim1_now;
                        end
                        if (idx_inc >= lim1_now) begin
                            st_d.seg   = SEG_TWO;
                            st_d.idx   = '0;
                            st_d.smp   = 1'b1;
                            st_d.bit_v = rx_i;
                        end else begin
                            st_d.idx = idx_inc;
                        end
                    end
                    SEG_TWO: begin
                        if (resync && restart) begin
                            // early edge fully absorbed: edge quantum acts as sync
                            st_d.seg  = SEG_ONE;
                            st_d.idx  = '0;
                            st_d.lim1 = seg1_len_i;
                            st_d.lim2 = seg2_len_i;
                            st_d.done = 1'b1;
                            st_d.txs  = 1'b1;
                        end else begin
                            if (resync) begin
                                st_d.done = 1'b1;
                                st_d.lim2 = lim2_now;
                            end
                            if (idx_inc >= lim2_now) begin
                                st_d.seg  = SEG_SYNC;
                                st_d.idx  = '0;
                                st_d.done = 1'b0;
                                st_d.txs  = 1'b1;
                            end else begin
                                st_d.idx = idx_inc;
                            end
                        end
                    end
                    default: begin
                        st_d.seg = SEG_SYNC;
                        st_d.idx = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.seg   <= SEG_SYNC;
            st_q.idx   <= '0;
            st_q.lim1  <= '0;
            st_q.lim2  <= '0;
            st_q.done  <= 1'b0;
            st_q.bit_v <= 1'b1;
            st_q.smp   <= 1'b0;
            st_q.txs   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_bit_o = st_q.bit_v;
    assign sample_o = st_q.smp;
    assign tx_o     = st_q.txs;

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int SJW_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tq_en_i,
    input  logic              rx_i,
    input  logic              idle_i,
    input  logic [SEG1_W-1:0] seg1_cfg_i,
    input  logic [SEG2_W-1:0] seg2_cfg_i,
    input  logic [SJW_W-1:0]  sjw_cfg_i,
    output logic              rx_bit_o,
    output logic              sample_o,
    output logic              tx_o
);

    // wide enough for the longest first part plus the largest extension
    localparam int LIM_W = $clog2((1 << SEG1_W) + (1 << SJW_W) + 1);

    logic             fall;
    logic [LIM_W-1:0] seg1_len;
    logic [LIM_W-1:0] seg2_len;
    logic [LIM_W-1:0] sjw_len;

    assign seg1_len = LIM_W'(seg1_cfg_i) + LIM_W'(1);
    assign seg2_len = LIM_W'(seg2_cfg_i) + LIM_W'(1);
    assign sjw_len  = LIM_W'(sjw_cfg_i)  + LIM_W'(1);

    can_bt_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tq_en_i (tq_en_i),
        .rx_i    (rx_i),
        .fall_o  (fall)
    );

    can_bt_seq #(
        .LIM_W (LIM_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tq_en_i    (tq_en_i),
        .rx_i       (rx_i),
        .idle_i     (idle_i),
        .fall_i     (fall),
        .seg1_len_i (seg1_len),
        .seg2_len_i (seg2_len),
        .sjw_len_i  (sjw_len),
        .rx_bit_o   (rx_bit_o),
        .sample_o   (sample_o),
        .tx_o       (tx_o)
    );

endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tq_en_i,
    input logic rx_i,
    input logic rx_bit_o,
    input logic sample_o,
    input logic tx_o
);

    a_r10_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_o && tx_o));

    a_r10_strobe_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o || tx_o) |-> $past(tq_en_i));

    a_r3_sample_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> (rx_bit_o == $past(rx_i)));

    a_r3_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sample_o |-> $stable(rx_bit_o));

    a_r3_sample_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> !sample_o);

    a_r2_tx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_o |=> !tx_o);

endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tq_en_i  (tq_en_i),
    .rx_i     (rx_i),
    .rx_bit_o (rx_bit_o),
    .sample_o (sample_o),
    .tx_o     (tx_o)
);

// File: tb/can_bit_timing_test.sv
`timescale 1ns/1ps
module can_bit_timing_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tq_en = 1'b0;
    logic       rx = 1'b1;
    logic       idle = 1'b0;
    logic [3:0] c1 = 4'd3;
    logic [2:0] c2 = 3'd2;
    logic [1:0] cj = 2'd1;
    logic       rx_bit, smp, txs;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int    p, l1e, l2e, L1, L2, SJW;
    bit    clamp, mdone, mprev, mbit;
    string tag;

    always #2.5 clk = ~clk;

    can_bit_timing uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tq_en_i    (tq_en),
        .rx_i       (rx),
        .idle_i     (idle),
        .seg1_cfg_i (c1),
        .seg2_cfg_i (c2),
        .sjw_cfg_i  (cj),
        .rx_bit_o   (rx_bit),
        .sample_o   (smp),
        .tx_o       (txs)
    );

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    task automatic do_reset(input int s1, input int s2, input int sj);
        rst_n = 1'b0; tq_en = 1'b0; rx = 1'b1; idle = 1'b0;
        c1 = 4'(s1 - 1); c2 = 3'(s2 - 1); cj = 2'(sj - 1);
        repeat (2) @(negedge clk);
        chk(smp, 1'b0, "R1", "sample_o in reset");
        chk(txs, 1'b0, "R1", "tx_o in reset");
        chk(rx_bit, 1'b1, "R1", "rx_bit_o in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_bit, 1'b1, "R1", "rx_bit_o after release");
        L1 = s1; L2 = s2; SJW = imin(sj, s2); clamp = (sj > s2);
        p = 0; l1e = L1; l2e = L2; mdone = 0; mprev = 1; mbit = 1; tag = "R2";
    endtask

    // one quantum: drive, advance model, check outputs after the edge
    task automatic tick(input logic rxv, input logic idv);
        bit fall, es, et;
        int pn, i, e;
        rx = rxv; idle = idv; tq_en = 1'b1;
        fall = mprev && !rxv; es = 0; et = 0; pn = p + 1;
        if (fall && idv) begin
            pn = 1; l1e = L1; l2e = L2; mdone = 1; tag = "R4";
        end else if (p == 0) begin
            pn = 1; l1e = L1; l2e = L2; mdone = fall;
            tag = fall ? "R5" : "R2";
        end else if (p <= l1e) begin
            if (fall && !mdone) begin
                mdone = 1; l1e = L1 + imin(p, SJW); tag = clamp ? "R9" : "R6";
            end else if (fall) begin
                tag = "R8";
            end
            if (p == l1e) begin es = 1; mbit = rxv; end
        end else begin
            i = p - l1e - 1;
            if (fall && !mdone) begin
                mdone = 1; e = L2 - i; tag = clamp ? "R9" : "R7";
                if (e <= SJW) begin
                    et = 1; pn = 1; l1e = L1; l2e = L2;
                end else begin
                    l2e = L2 - SJW;
                end
            end else if (fall) begin
                tag = "R8";
            end
            if (!et && p >= l1e + l2e) begin et = 1; pn = 0; mdone = 0; end
        end
        mprev = rxv; p = pn;
        @(posedge clk);
        @(negedge clk);
        tq_en = 1'b0;
        chk(smp, es, tag, "sample_o");
        chk(txs, et, tag, "tx_o");
        chk(rx_bit, mbit, (es ? "R3" : tag), "rx_bit_o");
        chk(smp && txs, 1'b0, "R10", "both strobes");
        if ($urandom_range(1, 0) == 1) begin
            @(posedge clk);
            @(negedge clk);
            chk(smp, 1'b0, "R3", "sample_o without tick");
            chk(txs, 1'b0, "R10", "tx_o without tick");
            chk(rx_bit, mbit, "R3", "rx_bit_o hold");
        end
    endtask

    task automatic run_round(input int s1, input int s2, input int sj, input int nt);
        logic lv;
        int   left;
        do_reset(s1, s2, sj);
        for (int k = 0; k < 4; k++) tick(1'b1, 1'b1);
        lv = 1'b0; left = 1 + int'($urandom_range(3, 0));
        for (int k = 0; k < nt; k++) begin
            if (left == 0) begin
                lv = ~lv;
                left = 1 + int'($urandom_range(2 * (1 + s1 + s2), 0));
            end
            left--;
            tick(lv, (k < 2) || ($urandom_range(15, 0) == 0));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed: nominal, shortest bit with clamp, longest bit, clamp
        run_round(4, 3, 2, 400);
        run_round(1, 1, 4, 400);
        run_round(16, 8, 4, 600);
        run_round(6, 2, 3, 400);
        run_round(2, 8, 1, 400);
        for (int r = 0; r < 6; r++) begin
            run_round(1 + int'($urandom_range(15, 0)), 1 + int'($urandom_range(7, 0)),
                      1 + int'($urandom_range(3, 0)), 500);
        end
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=%0d expected<%0d cycles", 150000, 150000);
            report();
            $finish;
        end
    end

endmodule